// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block holds a 64-bit interrupt command, split into a high and a low 32-bit word, and turns it into a set of target agents. Software first writes the high word, whose top byte names the destination, and then writes the low word. The low-word write stores the command and launches the send in the same clock edge.

From the low word the block takes the vector, delivery mode, destination mode, level, trigger and shorthand fields. It then compares the destination against every agent. Each agent supplies its own physical ID, logical ID and format code. The comparison is either an exact physical match, a flat bitmask match, or a cluster match made of a group nibble and a member nibble.

The result is a registered accept bitmap with one bit per agent. Alongside it come a one-cycle accepted pulse, the decoded command fields, and an error pulse when an agent's format code is not one that is supported. Choosing one target among several lowest-priority candidates is left to the consumer of the bitmap.

Top module: `ipi_dispatch`

## Requirements
- R1: A low-word write stores the written value with bit 12 forced to 0; the stored low word is visible on `cmd_lo`.
- R2: A high-word write keeps only bits [31:24] (the destination) and stores 0 in bits [23:0]; the stored high word is visible on `cmd_hi`.
- R3: With shorthand 0 and physical mode (low-word bit 11 = 0), an agent is selected when the destination equals its physical ID.
- R4: With shorthand 0 and physical mode, destination 0xFF selects every agent.
- R5: With shorthand 0, physical mode and delivery mode 3'b001 (lowest priority, low-word bits [10:8]), no agent is selected.
- R6: With shorthand 0, logical mode (bit 11 = 1) and an agent format code of 4'hF, the agent is selected when the destination AND its logical ID is nonzero.
- R7: With shorthand 0, logical mode and format code 4'h0, destination 0xFF selects the agent. Otherwise the agent is selected when both upper nibbles are equal and the AND of the lower nibbles is nonzero.
- R8: Shorthand 1 (low-word bits [19:18]) selects only the sending agent.
- R9: Shorthand 2 selects every agent, and shorthand 3 selects every agent except the sender.
- R10: `accepted` is high for exactly the one cycle after a send in which at least one agent was selected. `accept_map` holds the selection for that cycle and is zero in every other cycle.
- R11: In a logical-mode send with shorthand 0, an agent whose format code is neither 4'h0 nor 4'hF is not selected, and `fmt_error` pulses for that one cycle.
- R12: With each send, `vector` (bits [7:0]), `dmode` (bits [10:8]), `level` (bit 14) and `trig` (bit 15) show the fields of the written low word.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_hi | input | 1 | 1 selects the high word, 0 the low word (launches a send) |
| wr_data | input | 32 | Write data |
| sender | input | SW | Index of the sending agent |
| phys_ids | input | N*8 | Physical ID of each agent, agent i in bits [8i+7:8i] |
| log_ids | input | N*8 | Logical ID of each agent |
| fmts | input | N*4 | Format code of each agent |
| cmd_lo | output | 32 | Stored low word |
| cmd_hi | output | 32 | Stored high word |
| accept_map | output | N | Selected agents, valid in the cycle after a send |
| accepted | output | 1 | At least one agent was selected |
| fmt_error | output | 1 | An unsupported format code was met |
| vector | output | 8 | Vector of the last send |
| dmode | output | 3 | Delivery mode of the last send |
| level | output | 1 | Level bit of the last send |
| trig | output | 1 | Trigger bit of the last send |

## Verification
Every result comes from a single register stage. Stored words, the bitmap, the pulses and the decoded fields therefore all change at the clock edge that takes the write, and are due in the cycle right after it. The bench drives each write at a falling edge and samples the outputs at the next falling edge. One cycle later it samples again to confirm that `accepted`, `accept_map` and `fmt_error` have returned to zero.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int N  = 4,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_hi,
  input  logic [31:0]    wr_data,
  input  logic [SW-1:0]  sender,
  input  logic [N*8-1:0] phys_ids,
  input  logic [N*8-1:0] log_ids,
  input  logic [N*4-1:0] fmts,
  output logic [31:0]    cmd_lo,
  output logic [31:0]    cmd_hi,
  output logic [N-1:0]   accept_map,
  output logic           accepted,
  output logic           fmt_error,
  output logic [7:0]     vector,
  output logic [2:0]     dmode,
  output logic           level,
  output logic           trig
);
  localparam logic [7:0] BCAST = 8'hFF;

  logic       send;
  logic [7:0] dest;
  logic       logical;
  logic [1:0] shand;
  logic [N-1:0] hit;
  logic [N-1:0] bad;

  assign send    = wr_en && !wr_hi;
  assign dest    = cmd_hi[31:24];
  assign logical = wr_data[11];
  assign shand   = wr_data[19:18];

  always_comb begin
    hit = '0;
    bad = '0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] pid, lid;
      logic [3:0] fm;
      pid = phys_ids[i*8 +: 8];
      lid = log_ids[i*8 +: 8];
      fm  = fmts[i*4 +: 4];
      unique case (shand)
        2'd1: hit[i] = (SW'(i) == sender);
        2'd2: hit[i] = 1'b1;
        2'd3: hit[i] = (SW'(i) != sender);
        default: begin
          if (!logical) begin
            if (wr_data[10:8] != 3'b001)
              hit[i] = (dest == BCAST) || (dest == pid);
          end else if (fm == 4'hF) begin
            hit[i] = |(dest & lid);
          end else if (fm == 4'h0) begin
            hit[i] = (dest == BCAST) ||
                     ((dest[7:4] == lid[7:4]) && |(dest[3:0] & lid[3:0]));
          end else begin
            bad[i] = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_lo     <= '0;
      cmd_hi     <= '0;
      accept_map <= '0;
      accepted   <= 1'b0;
      fmt_error  <= 1'b0;
      vector     <= '0;
      dmode      <= '0;
      level      <= 1'b0;
      trig       <= 1'b0;
    end else begin
      accept_map <= send ? hit : '0;
      accepted   <= send && (hit != '0);
      fmt_error  <= send && (bad != '0);
      if (wr_en && wr_hi) cmd_hi <= {wr_data[31:24], 24'h0};
      if (send) begin
        cmd_lo <= {wr_data[31:13], 1'b0, wr_data[11:0]};
        vector <= wr_data[7:0];
        dmode  <= wr_data[10:8];
        level  <= wr_data[14];
        trig   <= wr_data[15];
      end
    end
  end

  // R1
  lo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> !cmd_lo[12]);
  // R2
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (cmd_hi[23:0] == 24'h0));
  // R5
  lowpri_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && shand == 2'd0 && !logical && wr_data[10:8] == 3'b001) |=> (accept_map == '0));
  // R8
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && shand == 2'd1) |=> ($countones(accept_map) == 1));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !send |=> (!accepted && accept_map == '0 && !fmt_error));
  // R10
  accept_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |-> (accept_map != '0));
endmodule

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_hi = 0;
  logic [31:0] wr_data = '0;
  logic [SW-1:0] sender = '0;
  logic [N*8-1:0] phys_ids = {8'h04, 8'h03, 8'h02, 8'h01};
  logic [N*8-1:0] log_ids = {8'h08, 8'h04, 8'h02, 8'h01};
  logic [N*4-1:0] fmts = 16'hFFFF;
  logic [31:0] cmd_lo, cmd_hi;
  logic [N-1:0] accept_map;
  logic accepted, fmt_error, level, trig;
  logic [7:0] vector;
  logic [2:0] dmode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_dispatch #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .sender(sender), .phys_ids(phys_ids), .log_ids(log_ids), .fmts(fmts),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .accept_map(accept_map), .accepted(accepted),
    .fmt_error(fmt_error), .vector(vector), .dmode(dmode), .level(level), .trig(trig));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [7:0] dest, input logic [31:0] lo,
                      input logic [3:0] exp_map, input logic exp_err);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_data = {dest, 24'hFFFFFF};
    @(negedge clk); wr_hi = 0; wr_data = lo;
    @(negedge clk); wr_en = 0;
    check({tag, " map"}, 32'(accept_map), 32'(exp_map));
    check({tag, " R10 accepted"}, 32'(accepted), 32'(exp_map != 0));
    check({tag, " R11 fmt_error"}, 32'(fmt_error), 32'(exp_err));
    @(negedge clk);
    check({tag, " R10 pulse end"}, {30'(accept_map), accepted, fmt_error}, 32'h0);
  endtask

  task automatic t_reset();
    check("R13 reset lo", cmd_lo, 0);
    check("R13 reset hi", cmd_hi, 0);
    check("R13 reset flags", {accept_map, accepted, fmt_error, vector, dmode, level, trig}, 0);
  endtask

  task automatic t_fields();
    send("R3 physical exact", 8'h03, 32'h0000_D0A5, 4'b0100, 0);
    check("R1 bit12 cleared", cmd_lo, 32'h0000_C0A5);
    check("R2 hi masked", cmd_hi, 32'h0300_0000);
    check("R12 fields", {vector, dmode, level, trig}, {8'hA5, 3'b000, 1'b1, 1'b1});
  endtask

  task automatic t_physical();
    send("R4 broadcast", 8'hFF, 32'h0000_0020, 4'b1111, 0);
    send("R3 no match", 8'h09, 32'h0000_0020, 4'b0000, 0);
    send("R5 lowpri physical", 8'hFF, 32'h0000_0121, 4'b0000, 0);
    check("R12 dmode", 32'(dmode), 32'h1);
  endtask

  task automatic t_flat();
    fmts = 16'hFFFF; log_ids = {8'h08, 8'h04, 8'h02, 8'h01};
    send("R6 flat", 8'h05, 32'h0000_0830, 4'b0101, 0);
    send("R6 flat lowpri logical", 8'h0A, 32'h0000_0931, 4'b1010, 0);
    send("R6 flat none", 8'h30, 32'h0000_0830, 4'b0000, 0);
  endtask

  task automatic t_cluster();
    fmts = 16'h0000; log_ids = {8'h23, 8'h21, 8'h12, 8'h11};
    send("R7 cluster 2", 8'h21, 32'h0000_0840, 4'b1100, 0);
    send("R7 cluster 1", 8'h13, 32'h0000_0840, 4'b0011, 0);
    send("R7 cluster all", 8'hFF, 32'h0000_0840, 4'b1111, 0);
    send("R7 cluster none", 8'h30, 32'h0000_0840, 4'b0000, 0);
  endtask

  task automatic t_badfmt();
    fmts = 16'hFF5F; log_ids = {8'h08, 8'h04, 8'h02, 8'h01};
    send("R11 bad format", 8'hFF, 32'h0000_0850, 4'b1101, 1);
    fmts = 16'hFFFF;
  endtask

  task automatic t_shorthand();
    sender = 2'd2;
    send("R8 self", 8'h00, 32'h0004_0060, 4'b0100, 0);
    send("R9 all incl", 8'h00, 32'h0008_0060, 4'b1111, 0);
    send("R9 all excl", 8'h00, 32'h000C_0060, 4'b1011, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_fields();
    t_physical();
    t_flat();
    t_cluster();
    t_badfmt();
    t_shorthand();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; $display("FAIL watchdog: actual hung expected done"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule